// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter with Cascade Enables

The block is a synchronous up counter, four bits wide by default, that shares one rising-edge clock with the logic around it. It can be preset from a parallel data word. An active-low clear forces it to zero at once, without waiting for a clock edge. It only advances when two separate count enables are both high.

The first enable, the parallel enable, only gates counting. The second, the trickle enable, gates counting and also qualifies the terminal-count flag. This split lets several stages be chained into a wider synchronous counter. Each stage's terminal count drives the trickle enable of the next stage. A single shared signal on all parallel enables starts and stops the whole chain.

A preset wired back from the count or from the terminal-count flag gives a divide-by-N loop that skips the states outside the wanted range.

Top module: `pcnt_top`

## Requirements
- R1: While `rst_ni` is low, `count_o` is all zeros. It reaches zero as soon as `rst_ni` falls, with no clock edge needed, and whatever the other inputs are.
- R2: The clear has priority over a preset. With `rst_ni` low and `load_ni` low, a rising clock edge leaves `count_o` at zero.
- R3: With `rst_ni` high and `load_ni` low, each rising edge copies `data_i` into `count_o`. Bit i of `data_i` goes to bit i of `count_o`. This happens whatever the levels of `en_par_i` and `en_trk_i`.
- R4: With `rst_ni`, `load_ni`, `en_par_i` and `en_trk_i` all high, each rising edge adds one to `count_o`.
- R5: With `load_ni` high and either enable low, `count_o` keeps its value across the rising edge.
- R6: An increment from the all-ones value gives all zeros.
- R7: `tc_o` is high exactly when every bit of `count_o` is one and `en_trk_i` is high. `en_par_i` has no effect on `tc_o`.
- R8: `tc_o` is combinational. It follows a change of `en_trk_i` or of the count within the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous clear, active low |
| load_ni | input | 1 | Synchronous preset, active low |
| data_i | input | WIDTH | Preset value |
| en_par_i | input | 1 | Count enable that gates counting only |
| en_trk_i | input | 1 | Count enable that also qualifies the terminal count |
| count_o | output | WIDTH | Current count |
| tc_o | output | 1 | Terminal count flag |

## Verification
Two pairs of functions can meet in one cycle.

The first pair is a preset and a count. The bench lowers `load_ni` while both enables are high, including while the count is at all ones. Under R3 the data word must win, with no increment and no wrap.

The second pair is a clear and a preset. The bench pulls `rst_ni` low between clock edges while `load_ni` is low. It checks that the count is zero before the next edge and still zero after it.

A behavioural model in the bench applies this order of priority every cycle and compares both outputs.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2
  } op_e;
endpackage

// File: rtl/pcnt_ctl.sv
module pcnt_ctl
  import pcnt_pkg::*;
(
  input  logic load_ni,
  input  logic en_par_i,
  input  logic en_trk_i,
  output op_e  op_o
);
  // preset wins over the enables
  always_comb begin
    if (!load_ni)                 op_o = OP_LOAD;
    else if (en_par_i && en_trk_i) op_o = OP_INC;
    else                          op_o = OP_HOLD;
  end
endmodule

// File: rtl/pcnt_reg.sv
module pcnt_reg
  import pcnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  op_e              op_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] inc;
  logic [WIDTH-1:0] q_d;

  assign carry[0] = 1'b1;

  // bit toggles when every lower bit is one
  for (genvar i = 0; i < WIDTH; i++) begin : g_inc
    assign inc[i]     = q_o[i] ^ carry[i];
    assign carry[i+1] = carry[i] & q_o[i];
  end

  always_comb begin
    unique case (op_i)
      OP_LOAD: q_d = data_i;
      OP_INC:  q_d = inc;
      default: q_d = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/pcnt_tc.sv
module pcnt_tc #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             en_trk_i,
  output logic             tc_o
);
  logic [WIDTH:0] all_ones;

  assign all_ones[0] = en_trk_i;
  for (genvar i = 0; i < WIDTH; i++) begin : g_and
    assign all_ones[i+1] = all_ones[i] & q_i[i];
  end
  assign tc_o = all_ones[WIDTH];
endmodule

// File: rtl/pcnt_top.sv
module pcnt_top
  import pcnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             en_par_i,
  input  logic             en_trk_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o
);
  op_e op;

  pcnt_ctl u_ctl (
    .load_ni  (load_ni),
    .en_par_i (en_par_i),
    .en_trk_i (en_trk_i),
    .op_o     (op)
  );

  pcnt_reg #(.WIDTH(WIDTH)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .data_i (data_i),
    .q_o    (count_o)
  );

  pcnt_tc #(.WIDTH(WIDTH)) u_tc (
    .q_i      (count_o),
    .en_trk_i (en_trk_i),
    .tc_o     (tc_o)
  );
endmodule

// File: rtl/pcnt_chk.sv
module pcnt_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_ni,
  input logic [WIDTH-1:0] data_i,
  input logic             en_par_i,
  input logic             en_trk_i,
  input logic [WIDTH-1:0] count_o,
  input logic             tc_o
);
  localparam logic [WIDTH-1:0] ONES = '1;

  // R1 R2
  clear_zero_chk: assert property (@(posedge clk_i) !rst_ni |-> count_o == '0);

  // R3
  load_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> count_o == $past(data_i));

  // R4
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && en_par_i && en_trk_i && count_o != ONES)
      |=> count_o == $past(count_o) + WIDTH'(1));

  // R6
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && en_par_i && en_trk_i && count_o == ONES) |=> count_o == '0);

  // R5
  hold_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !(en_par_i && en_trk_i)) |=> $stable(count_o));

  // R7
  tc_needs_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (count_o == ONES && en_trk_i));

  // R7 R8
  tc_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == ONES && en_trk_i) |-> tc_o);
endmodule

bind pcnt_top pcnt_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .load_ni  (load_ni),
  .data_i   (data_i),
  .en_par_i (en_par_i),
  .en_trk_i (en_trk_i),
  .count_o  (count_o),
  .tc_o     (tc_o)
);

// File: tb/sim_pcnt_top.sv
`timescale 1ns/1ps
module sim_pcnt_top;
  localparam int W = 4;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_n = 1'b1;
  logic [W-1:0] data = '0;
  logic         en_p = 1'b0;
  logic         en_t = 1'b0;
  logic [W-1:0] count;
  logic         tc;

  int total = 0;
  int bad = 0;
  int model = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pcnt_top #(.WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data),
    .en_par_i(en_p), .en_trk_i(en_t), .count_o(count), .tc_o(tc)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_tc();
    return (model == MAXV && en_t) ? 1 : 0;
  endfunction

  // one clock: model updates at the edge, outputs compared 1 ns later
  task automatic step(input string req);
    @(posedge clk);
    if (!rst_n)                model = 0;
    else if (!load_n)          model = int'(data);
    else if (en_p && en_t)     model = (model + 1) % (MAXV + 1);
    #1;
    chk(req, int'(count), model);
    chk({req, " tc"}, int'(tc), model_tc());
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) step("R1");
    rst_n = 1'b1;
    // R5 hold with both enables low
    step("R5");
    // R3 load with enables low
    load_n = 1'b0; data = 4'hA; step("R3");
    // R3 load wins over active enables
    en_p = 1'b1; en_t = 1'b1; data = 4'h3; step("R3");
    load_n = 1'b1;
    // R4 increments
    for (int i = 0; i < 5; i++) step("R4");
    // R5 hold with one enable low
    en_p = 1'b0; step("R5"); step("R5");
    en_p = 1'b1; en_t = 1'b0; step("R5");
    // R7 terminal count at all ones
    load_n = 1'b0; data = 4'hF; en_t = 1'b1; step("R3");
    load_n = 1'b1; en_p = 1'b0;
    #0.5 chk("R7 par ignored", int'(tc), 1);
    en_t = 1'b0;
    #0.5 chk("R8 tc drop", int'(tc), 0);
    en_t = 1'b1;
    #0.5 chk("R8 tc rise", int'(tc), 1);
    // R3 load at all ones with counting on: no wrap
    en_p = 1'b1; load_n = 1'b0; data = 4'hF; step("R3");
    // R6 wrap
    load_n = 1'b1; step("R6");
    chk("R6 zero", int'(count), 0);
    step("R4");
    // R1 R2 clear mid-cycle during a preset
    load_n = 1'b0; data = 4'h9;
    #0.5 rst_n = 1'b0;
    #0.2 chk("R1 async", int'(count), 0);
    step("R2");
    rst_n = 1'b1;
    step("R3");
    // mixed pattern
    load_n = 1'b1;
    for (int i = 0; i < 60; i++) begin
      en_p   = (i % 7) != 3;
      en_t   = (i % 5) != 2;
      load_n = (i % 13) != 6;
      data   = W'(i * 3);
      step("R4 mix");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule